// File: doc/BRIEF.md
# Serial Configuration Port for a Dual Synthesizer

This block is the programming front end of a two-loop frequency synthesizer. A host shifts 24-bit words in over three wires: serial data, serial clock and a load strobe. When the load strobe rises, the word is copied into one of four configuration latches. Two of these latches set up the reference dividers, and two set up the feedback dividers. The latched bits are decoded into the control values the synthesizer core consumes:
- reference and feedback divide values, with a legality flag on each reference value;
- the fractional numerator and modulus;
- a charge-pump current in units of one step;
- phase-detector polarities;
- a monitor multiplexer select;
- counter resets and power states.

The block also drives two general-purpose outputs. They either carry static levels or, in fast-lock mode, sink current while a high charge-pump gain is selected.

All three serial wires are oversampled by the block's own clock through a synchronizer. Each edge is acted on a fixed number of cycles after it arrives. Reset puts both loops into power-down and drives both general-purpose outputs low.

Top module: `cfg_serial_port`

## Requirements
- R1: Each rising serial-clock edge shifts the data bit into a 24-bit register, first bit ending up at bit 23 (MSB first); bits 1:0 of the register, the last two bits shifted, form the latch address: 00 IF reference, 01 IF feedback, 10 RF reference, 11 RF feedback.
- R2: A rising load-strobe edge writes the whole shift register into the addressed latch only; the other three latches keep their contents.
- R3: Without a load-strobe rising edge no latch and no decoded output changes, however many bits are shifted.
- R4: In both reference latches bits 16:2 are the 15-bit reference divide value, output as is, with a legality flag that is high exactly when the value is 3 or more.
- R5: In the RF reference latch, bits 21:18 are current weights 8, 4, 2, 1 forming code c, and the charge-pump current output is (c+1)*100 (100 to 1600); bit 17 is the RF phase-detector polarity.
- R6: In the IF reference latch, bit 23 selects a common reference path, bit 22 selects a fractional modulus of 16 (1) or 15 (0), bits 21:19 are the monitor select, bit 18 the IF x8 gain and bit 17 the IF polarity.
- R7: IF feedback latch: bits 16:5 are the B count and bits 4:2 the A count. RF feedback latch: bits 20:11 are the B count, bits 10:6 the A count and bits 5:2 the fractional numerator.
- R8: With IF feedback bit 20 clear, both general-purpose outputs are driven, output 0 at the level of IF feedback bit 17 and output 1 at bit 18.
- R9: With IF feedback bit 20 set (fast-lock), output 0 is driven low while RF reference bit 21 (the 8x weight) is set and released otherwise, and output 1 is driven low while IF reference bit 18 (x8 gain) is set and released otherwise.
- R10: In each feedback latch, bit 23 is the counter reset and bit 22 the power-down bit. A loop is powered only when its enable pin is high and its power-down bit is clear. IF feedback bit 21 is the power-down mode select, and RF feedback bit 21 is the prescaler select.
- R11: After reset, both power-down bits are set and every other latched bit is zero, so both loops are off and both general-purpose outputs are driven low.
- R12: Shifting and latching work normally while both enable pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial wires |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe, rising edge latches |
| rf_en | input | 1 | RF loop enable pin |
| if_en | input | 1 | IF loop enable pin |
| if_ref_div | output | 15 | IF reference divide value |
| if_ref_legal | output | 1 | IF reference value is at least 3 |
| rf_ref_div | output | 15 | RF reference divide value |
| rf_ref_legal | output | 1 | RF reference value is at least 3 |
| rf_cp_current | output | 11 | RF charge-pump current in units |
| rf_pd_pol | output | 1 | RF phase-detector polarity |
| if_cp_x8 | output | 1 | IF charge-pump x8 gain |
| if_pd_pol | output | 1 | IF phase-detector polarity |
| mon_sel | output | 3 | Monitor multiplexer select |
| ref_common | output | 1 | Common reference path select |
| frac_mod | output | 5 | Fractional modulus, 15 or 16 |
| if_fb_b | output | 12 | IF feedback B count |
| if_fb_a | output | 3 | IF feedback A count |
| rf_fb_b | output | 10 | RF feedback B count |
| rf_fb_a | output | 5 | RF feedback A count |
| rf_frac | output | 4 | RF fractional numerator |
| if_powered | output | 1 | IF loop powered |
| rf_powered | output | 1 | RF loop powered |
| if_cnt_rst | output | 1 | IF counter reset |
| rf_cnt_rst | output | 1 | RF counter reset |
| if_pd_mode | output | 1 | IF power-down mode select |
| rf_presc_hi | output | 1 | RF prescaler select |
| gp_out | output | 2 | General-purpose output levels |
| gp_oe | output | 2 | General-purpose output drive enables |

## Verification
Each serial wire passes through two synchronizer flops and an edge register. A shift or a latch write therefore takes effect on the third rising clock edge after the wire changes. All decoded outputs are combinational from the latches, so they are valid right after that edge.

The bench holds every serial level for four clock cycles and keeps the load strobe high for four. It then waits eight more cycles before sampling on a falling edge, so every sample falls well after the three-edge latency. Checks that expect no change, such as shifting without a strobe or a write to another latch, sample on the same schedule.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

   localparam int ADDR_W    = 2;
   localparam int NUM_LATCH = 4;

   // Latch index equals the address in the two last-shifted bits.
   typedef enum logic [ADDR_W-1:0] {
      SEL_IF_REF = 2'b00,
      SEL_IF_FB  = 2'b01,
      SEL_RF_REF = 2'b10,
      SEL_RF_FB  = 2'b11
   } latch_sel_e;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int STAGES = 2,
   parameter int W      = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] lvl,
   output logic [W-1:0] rise
);

   logic [STAGES-1:0][W-1:0] st;
   logic [W-1:0]             prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[0] <= '0;
      else        st[0] <= din;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st[k] <= '0;
         else        st[k] <= st[k-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= st[STAGES-1];
   end

   assign lvl  = st[STAGES-1];
   assign rise = st[STAGES-1] & ~prev;

endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift,
   input  logic         din,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (shift) q <= {q[W-2:0], din};
   end

endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank #(
   parameter int W  = 24,
   parameter int N  = 4,
   parameter int AW = 2,
   parameter logic [N*W-1:0] RST_FLAT = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [AW-1:0]       sel,
   input  logic [W-1:0]        d,
   output logic [N-1:0][W-1:0] q
);

   for (genvar i = 0; i < N; i++) begin : g_latch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[i] <= RST_FLAT[i*W +: W];
         else if (wr && (sel == AW'(i)))
            q[i] <= d;
      end
   end

endmodule

// File: rtl/cfg_field_decode.sv
module cfg_field_decode #(
   parameter int WORD_W      = 24,
   parameter int REF_W       = 15,
   parameter int CP_W        = 4,
   parameter int CP_STEP     = 100,
   parameter int CUR_W       = 11,
   parameter int MUX_W       = 3,
   parameter int IF_B_W      = 12,
   parameter int IF_A_W      = 3,
   parameter int RF_B_W      = 10,
   parameter int RF_A_W      = 5,
   parameter int FRAC_W      = 4,
   parameter int MIN_REF_DIV = 3
) (
   input  logic [WORD_W-1:0] if_ref_w,
   input  logic [WORD_W-1:0] rf_ref_w,
   input  logic [WORD_W-1:0] if_fb_w,
   input  logic [WORD_W-1:0] rf_fb_w,
   input  logic              rf_en,
   input  logic              if_en,
   output logic [REF_W-1:0]  if_ref_div,
   output logic              if_ref_legal,
   output logic [REF_W-1:0]  rf_ref_div,
   output logic              rf_ref_legal,
   output logic [CUR_W-1:0]  rf_cp_current,
   output logic              rf_pd_pol,
   output logic              if_cp_x8,
   output logic              if_pd_pol,
   output logic [MUX_W-1:0]  mon_sel,
   output logic              ref_common,
   output logic [FRAC_W:0]   frac_mod,
   output logic [IF_B_W-1:0] if_fb_b,
   output logic [IF_A_W-1:0] if_fb_a,
   output logic [RF_B_W-1:0] rf_fb_b,
   output logic [RF_A_W-1:0] rf_fb_a,
   output logic [FRAC_W-1:0] rf_frac,
   output logic              if_powered,
   output logic              rf_powered,
   output logic              if_cnt_rst,
   output logic              rf_cnt_rst,
   output logic              if_pd_mode,
   output logic              rf_presc_hi,
   output logic [1:0]        gp_out,
   output logic [1:0]        gp_oe
);

   localparam int DIV_LO   = 2;
   localparam int POL_POS  = DIV_LO + REF_W;
   localparam int GAIN_LO  = POL_POS + 1;
   localparam int MUX_LO   = GAIN_LO + 1;
   localparam int FR16_POS = WORD_W - 2;
   localparam int COMM_POS = WORD_W - 1;
   localparam int IFA_LO   = 2;
   localparam int IFB_LO   = IFA_LO + IF_A_W;
   localparam int LVL_LO   = IFB_LO + IF_B_W;
   localparam int FL_POS   = LVL_LO + 3;
   localparam int FRC_LO   = 2;
   localparam int RFA_LO   = FRC_LO + FRAC_W;
   localparam int RFB_LO   = RFA_LO + RF_A_W;
   localparam int MODE_POS = WORD_W - 3;
   localparam int PWDN_POS = WORD_W - 2;
   localparam int CRST_POS = WORD_W - 1;

   // Reference fields share one layout in both reference latches.
   logic [1:0][WORD_W-1:0] ref_w;
   logic [1:0][REF_W-1:0]  div;
   logic [1:0]             legal;

   assign ref_w = {rf_ref_w, if_ref_w};

   for (genvar g = 0; g < 2; g++) begin : g_ref
      assign div[g]   = ref_w[g][DIV_LO +: REF_W];
      assign legal[g] = (div[g] >= REF_W'(MIN_REF_DIV));
   end

   assign if_ref_div   = div[0];
   assign if_ref_legal = legal[0];
   assign rf_ref_div   = div[1];
   assign rf_ref_legal = legal[1];

   // RF charge pump: binary-weighted code plus one, times the step.
   logic [CP_W-1:0] cp_code;
   assign cp_code       = rf_ref_w[GAIN_LO +: CP_W];
   assign rf_cp_current = CUR_W'((32'(cp_code) + 32'd1) * CP_STEP);
   assign rf_pd_pol     = rf_ref_w[POL_POS];

   assign if_pd_pol  = if_ref_w[POL_POS];
   assign if_cp_x8   = if_ref_w[GAIN_LO];
   assign mon_sel    = if_ref_w[MUX_LO +: MUX_W];
   assign ref_common = if_ref_w[COMM_POS];
   assign frac_mod   = if_ref_w[FR16_POS] ? (FRAC_W+1)'(1 << FRAC_W)
                                          : (FRAC_W+1)'((1 << FRAC_W) - 1);

   assign if_fb_a = if_fb_w[IFA_LO +: IF_A_W];
   assign if_fb_b = if_fb_w[IFB_LO +: IF_B_W];
   assign rf_frac = rf_fb_w[FRC_LO +: FRAC_W];
   assign rf_fb_a = rf_fb_w[RFA_LO +: RF_A_W];
   assign rf_fb_b = rf_fb_w[RFB_LO +: RF_B_W];

   // Enable pins dominate; the power-down bit decides only when enabled.
   assign if_powered  = if_en & ~if_fb_w[PWDN_POS];
   assign rf_powered  = rf_en & ~rf_fb_w[PWDN_POS];
   assign if_cnt_rst  = if_fb_w[CRST_POS];
   assign rf_cnt_rst  = rf_fb_w[CRST_POS];
   assign if_pd_mode  = if_fb_w[MODE_POS];
   assign rf_presc_hi = rf_fb_w[MODE_POS];

   // General-purpose pins: static levels, or open-drain on a high gain.
   logic       fast;
   logic [1:0] lvl;
   logic [1:0] gain;

   assign fast = if_fb_w[FL_POS];
   assign lvl  = if_fb_w[LVL_LO +: 2];
   assign gain = {if_ref_w[GAIN_LO], rf_ref_w[GAIN_LO + CP_W - 1]};

   for (genvar g = 0; g < 2; g++) begin : g_gp
      assign gp_out[g] = fast ? 1'b0 : lvl[g];
      assign gp_oe[g]  = fast ? gain[g] : 1'b1;
   end

   logic unused_dec;
   assign unused_dec = ^{if_ref_w[1:0], rf_ref_w[1:0], if_fb_w[1:0],
                         rf_fb_w[1:0], rf_ref_w[WORD_W-1 -: 2],
                         if_fb_w[FL_POS-1], rf_fb_w[WORD_W-4:RFB_LO+RF_B_W]};

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
   import cfg_port_pkg::*;
#(
   parameter int WORD_W      = 24,
   parameter int SYNC_STAGES = 2,
   parameter int REF_W       = 15,
   parameter int CP_W        = 4,
   parameter int CP_STEP     = 100,
   parameter int MUX_W       = 3,
   parameter int IF_B_W      = 12,
   parameter int IF_A_W      = 3,
   parameter int RF_B_W      = 10,
   parameter int RF_A_W      = 5,
   parameter int FRAC_W      = 4,
   parameter int MIN_REF_DIV = 3,
   localparam int CUR_W      = $clog2(((1 << CP_W) * CP_STEP) + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              ser_load,
   input  logic              rf_en,
   input  logic              if_en,
   output logic [REF_W-1:0]  if_ref_div,
   output logic              if_ref_legal,
   output logic [REF_W-1:0]  rf_ref_div,
   output logic              rf_ref_legal,
   output logic [CUR_W-1:0]  rf_cp_current,
   output logic              rf_pd_pol,
   output logic              if_cp_x8,
   output logic              if_pd_pol,
   output logic [MUX_W-1:0]  mon_sel,
   output logic              ref_common,
   output logic [FRAC_W:0]   frac_mod,
   output logic [IF_B_W-1:0] if_fb_b,
   output logic [IF_A_W-1:0] if_fb_a,
   output logic [RF_B_W-1:0] rf_fb_b,
   output logic [RF_A_W-1:0] rf_fb_a,
   output logic [FRAC_W-1:0] rf_frac,
   output logic              if_powered,
   output logic              rf_powered,
   output logic              if_cnt_rst,
   output logic              rf_cnt_rst,
   output logic              if_pd_mode,
   output logic              rf_presc_hi,
   output logic [1:0]        gp_out,
   output logic [1:0]        gp_oe
);

   localparam int PWDN_POS = WORD_W - 2;
   localparam int CTL_BITS = 3;

   // Elaboration-time checks on the field budget of one word.
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cfg_serial_port: SYNC_STAGES must be at least 2");
   end
   if (2 + REF_W + 1 + MUX_W + 1 > WORD_W - 2) begin : g_bad_ref
      $error("cfg_serial_port: IF reference fields exceed word");
   end
   if (2 + REF_W + 1 + CP_W > WORD_W - 2) begin : g_bad_cp
      $error("cfg_serial_port: RF reference fields exceed word");
   end
   if (2 + IF_A_W + IF_B_W + 4 > WORD_W - CTL_BITS) begin : g_bad_iffb
      $error("cfg_serial_port: IF feedback fields exceed word");
   end
   if (2 + FRAC_W + RF_A_W + RF_B_W > WORD_W - CTL_BITS) begin : g_bad_rffb
      $error("cfg_serial_port: RF feedback fields exceed word");
   end

   localparam logic [WORD_W-1:0] RST_IF_REF = WORD_W'(SEL_IF_REF);
   localparam logic [WORD_W-1:0] RST_RF_REF = WORD_W'(SEL_RF_REF);
   localparam logic [WORD_W-1:0] RST_IF_FB  = (WORD_W'(1) << PWDN_POS) | WORD_W'(SEL_IF_FB);
   localparam logic [WORD_W-1:0] RST_RF_FB  = (WORD_W'(1) << PWDN_POS) | WORD_W'(SEL_RF_FB);
   localparam logic [NUM_LATCH*WORD_W-1:0] LATCH_RST =
      {RST_RF_FB, RST_RF_REF, RST_IF_FB, RST_IF_REF};

   logic [2:0] raw, lvl, rise;
   logic       sclk_rise, le_rise, data_s;

   assign raw = {ser_load, ser_clk, ser_data};

   cfg_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(raw), .lvl(lvl), .rise(rise)
   );

   assign data_s    = lvl[0];
   assign sclk_rise = rise[1];
   assign le_rise   = rise[2];

   logic unused_sync;
   assign unused_sync = ^{rise[0], lvl[2:1]};

   logic [WORD_W-1:0] sr_q;
   logic [ADDR_W-1:0] sr_addr;

   cfg_shift_reg #(.W(WORD_W)) u_sr (
      .clk(clk), .rst_n(rst_n), .shift(sclk_rise), .din(data_s), .q(sr_q)
   );

   assign sr_addr = sr_q[ADDR_W-1:0];

   logic [NUM_LATCH-1:0][WORD_W-1:0] lat_q;
   logic [WORD_W-1:0] lat_if_ref, lat_rf_ref, lat_if_fb, lat_rf_fb;

   cfg_latch_bank #(
      .W(WORD_W), .N(NUM_LATCH), .AW(ADDR_W), .RST_FLAT(LATCH_RST)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr(le_rise), .sel(sr_addr), .d(sr_q), .q(lat_q)
   );

   assign lat_if_ref = lat_q[SEL_IF_REF];
   assign lat_rf_ref = lat_q[SEL_RF_REF];
   assign lat_if_fb  = lat_q[SEL_IF_FB];
   assign lat_rf_fb  = lat_q[SEL_RF_FB];

   cfg_field_decode #(
      .WORD_W(WORD_W), .REF_W(REF_W), .CP_W(CP_W), .CP_STEP(CP_STEP),
      .CUR_W(CUR_W), .MUX_W(MUX_W), .IF_B_W(IF_B_W), .IF_A_W(IF_A_W),
      .RF_B_W(RF_B_W), .RF_A_W(RF_A_W), .FRAC_W(FRAC_W),
      .MIN_REF_DIV(MIN_REF_DIV)
   ) u_dec (
      .if_ref_w(lat_if_ref), .rf_ref_w(lat_rf_ref),
      .if_fb_w(lat_if_fb), .rf_fb_w(lat_rf_fb),
      .rf_en(rf_en), .if_en(if_en),
      .if_ref_div(if_ref_div), .if_ref_legal(if_ref_legal),
      .rf_ref_div(rf_ref_div), .rf_ref_legal(rf_ref_legal),
      .rf_cp_current(rf_cp_current), .rf_pd_pol(rf_pd_pol),
      .if_cp_x8(if_cp_x8), .if_pd_pol(if_pd_pol), .mon_sel(mon_sel),
      .ref_common(ref_common), .frac_mod(frac_mod),
      .if_fb_b(if_fb_b), .if_fb_a(if_fb_a), .rf_fb_b(rf_fb_b),
      .rf_fb_a(rf_fb_a), .rf_frac(rf_frac),
      .if_powered(if_powered), .rf_powered(rf_powered),
      .if_cnt_rst(if_cnt_rst), .rf_cnt_rst(rf_cnt_rst),
      .if_pd_mode(if_pd_mode), .rf_presc_hi(rf_presc_hi),
      .gp_out(gp_out), .gp_oe(gp_oe)
   );

endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
   parameter int WORD_W   = 24,
   parameter int REF_W    = 15,
   parameter int FL_POS   = 20,
   parameter int RF8_POS  = 21,
   parameter int PWDN_POS = 22
) (
   input logic              clk,
   input logic              rst_n,
   input logic              le_rise,
   input logic [1:0]        sr_addr,
   input logic [REF_W-1:0]  if_ref_div,
   input logic [REF_W-1:0]  rf_ref_div,
   input logic [WORD_W-1:0] if_fb_w,
   input logic [WORD_W-1:0] rf_ref_w,
   input logic              rf_en,
   input logic              rf_powered,
   input logic              if_powered,
   input logic [1:0]        gp_out,
   input logic [1:0]        gp_oe
);

   // R2: a write aimed elsewhere leaves the IF reference value alone
   assert_other_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (le_rise && sr_addr != 2'b00) |=> $stable(if_ref_div));

   // R3: without a strobe edge the RF reference value holds
   assert_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !le_rise |=> $stable(rf_ref_div));

   assert_gp_driven_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !if_fb_w[FL_POS] |-> (gp_oe == 2'b11));

   assert_fast_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      if_fb_w[FL_POS] |-> (gp_out == 2'b00));

   assert_fast_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (if_fb_w[FL_POS] && !rf_ref_w[RF8_POS]) |-> !gp_oe[0]);

   assert_pin_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rf_en |-> !rf_powered);

   assert_pwdn_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      if_fb_w[PWDN_POS] |-> !if_powered);

endmodule

bind cfg_serial_port cfg_serial_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .le_rise(le_rise), .sr_addr(sr_addr),
   .if_ref_div(if_ref_div), .rf_ref_div(rf_ref_div),
   .if_fb_w(lat_if_fb), .rf_ref_w(lat_rf_ref),
   .rf_en(rf_en), .rf_powered(rf_powered), .if_powered(if_powered),
   .gp_out(gp_out), .gp_oe(gp_oe)
);

// File: tb/cfg_serial_port_test.sv
module cfg_serial_port_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
   logic rf_en = 1'b1, if_en = 1'b1;

   logic [14:0] if_ref_div, rf_ref_div;
   logic        if_ref_legal, rf_ref_legal, rf_pd_pol, if_cp_x8, if_pd_pol;
   logic [10:0] rf_cp_current;
   logic [2:0]  mon_sel;
   logic        ref_common;
   logic [4:0]  frac_mod;
   logic [11:0] if_fb_b;
   logic [2:0]  if_fb_a;
   logic [9:0]  rf_fb_b;
   logic [4:0]  rf_fb_a;
   logic [3:0]  rf_frac;
   logic        if_powered, rf_powered, if_cnt_rst, rf_cnt_rst;
   logic        if_pd_mode, rf_presc_hi;
   logic [1:0]  gp_out, gp_oe;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   cfg_serial_port uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_load(ser_load), .rf_en(rf_en), .if_en(if_en),
      .if_ref_div(if_ref_div), .if_ref_legal(if_ref_legal),
      .rf_ref_div(rf_ref_div), .rf_ref_legal(rf_ref_legal),
      .rf_cp_current(rf_cp_current), .rf_pd_pol(rf_pd_pol),
      .if_cp_x8(if_cp_x8), .if_pd_pol(if_pd_pol), .mon_sel(mon_sel),
      .ref_common(ref_common), .frac_mod(frac_mod),
      .if_fb_b(if_fb_b), .if_fb_a(if_fb_a), .rf_fb_b(rf_fb_b),
      .rf_fb_a(rf_fb_a), .rf_frac(rf_frac),
      .if_powered(if_powered), .rf_powered(rf_powered),
      .if_cnt_rst(if_cnt_rst), .rf_cnt_rst(rf_cnt_rst),
      .if_pd_mode(if_pd_mode), .rf_presc_hi(rf_presc_hi),
      .gp_out(gp_out), .gp_oe(gp_oe)
   );

   // Word builders, field layout as in the requirements.
   function automatic logic [23:0] mk_ifref(logic com, logic f16, logic [2:0] mux,
                                            logic x8, logic pol, logic [14:0] div);
      return {com, f16, mux, x8, pol, div, 2'b00};
   endfunction
   function automatic logic [23:0] mk_rfref(logic [3:0] cp, logic pol, logic [14:0] div);
      return {2'b00, cp, pol, div, 2'b10};
   endfunction
   function automatic logic [23:0] mk_iffb(logic [2:0] ctl, logic [3:0] gpb,
                                           logic [11:0] b, logic [2:0] a);
      return {ctl, gpb, b, a, 2'b01};
   endfunction
   function automatic logic [23:0] mk_rffb(logic [2:0] ctl, logic [9:0] b,
                                           logic [4:0] a, logic [3:0] fr);
      return {ctl, b, a, fr, 2'b11};
   endfunction

   typedef struct packed {
      logic [23:0] w;
      logic [3:0]  id;
      logic [15:0] exp;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{mk_ifref(1'b0, 1'b0, 3'd5, 1'b0, 1'b1, 15'd1000), 4'd0, 16'd1000},
      '{mk_rfref(4'd15, 1'b1, 15'd32767),                 4'd1, 16'd32767},
      '{mk_rfref(4'd0,  1'b0, 15'd3),                     4'd2, 16'd100},
      '{mk_rfref(4'd8,  1'b0, 15'd3),                     4'd2, 16'd900},
      '{mk_rfref(4'd15, 1'b0, 15'd3),                     4'd2, 16'd1600},
      '{mk_iffb(3'd0, 4'd0, 12'd4095, 3'd7),              4'd3, 16'd4095},
      '{mk_iffb(3'd0, 4'd0, 12'd7, 3'd5),                 4'd4, 16'd5},
      '{mk_rffb(3'd0, 10'd1023, 5'd31, 4'd9),             4'd5, 16'd1023},
      '{mk_rffb(3'd0, 10'd40, 5'd17, 4'd9),               4'd6, 16'd17},
      '{mk_rffb(3'd0, 10'd40, 5'd17, 4'd15),              4'd7, 16'd15},
      '{mk_ifref(1'b0, 1'b1, 3'd6, 1'b0, 1'b0, 15'd50),   4'd8, 16'd6},
      '{mk_ifref(1'b0, 1'b1, 3'd6, 1'b0, 1'b0, 15'd50),   4'd9, 16'd16},
      '{mk_ifref(1'b0, 1'b0, 3'd6, 1'b0, 1'b0, 15'd50),   4'd9, 16'd15},
      '{mk_ifref(1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 15'd2),    4'd10, 16'd0},
      '{mk_ifref(1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 15'd3),    4'd10, 16'd1}
   };

   function automatic logic [15:0] obs(logic [3:0] id);
      case (id)
         4'd0:    return 16'(if_ref_div);
         4'd1:    return 16'(rf_ref_div);
         4'd2:    return 16'(rf_cp_current);
         4'd3:    return 16'(if_fb_b);
         4'd4:    return 16'(if_fb_a);
         4'd5:    return 16'(rf_fb_b);
         4'd6:    return 16'(rf_fb_a);
         4'd7:    return 16'(rf_frac);
         4'd8:    return 16'(mon_sel);
         4'd9:    return 16'(frac_mod);
         default: return 16'(if_ref_legal);
      endcase
   endfunction

   function automatic string tag_of(logic [3:0] id);
      case (id)
         4'd0, 4'd10: return "R4";
         4'd1:        return "R1";
         4'd2:        return "R5";
         4'd8, 4'd9:  return "R6";
         default:     return "R7";
      endcase
   endfunction

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic ticks(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_word(logic [23:0] w);
      for (int i = 23; i >= 0; i--) begin
         ser_data = w[i];
         ticks(4);
         ser_clk = 1'b1;
         ticks(4);
         ser_clk = 1'b0;
      end
      ticks(4);
   endtask

   task automatic load_word(logic [23:0] w);
      shift_word(w);
      ser_load = 1'b1;
      ticks(4);
      ser_load = 1'b0;
      ticks(8);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      ticks(3);
      rst_n = 1'b1;
      ticks(4);

      // R11: reset state with both enable pins high
      chk("R11 rf_powered", int'(rf_powered), 0);
      chk("R11 if_powered", int'(if_powered), 0);
      chk("R11 gp_out", int'(gp_out), 0);
      chk("R11 gp_oe", int'(gp_oe), 3);
      chk("R11 if_ref_div", int'(if_ref_div), 0);

      for (int k = 0; k < NV; k++) begin
         load_word(VECS[k].w);
         chk(tag_of(VECS[k].id), int'(obs(VECS[k].id)), int'(VECS[k].exp));
      end

      // R2: an RF reference write leaves IF reference intact
      load_word(mk_ifref(1'b1, 1'b0, 3'd2, 1'b1, 1'b1, 15'd1234));
      load_word(mk_rfref(4'd3, 1'b1, 15'd555));
      chk("R2 if_ref_div", int'(if_ref_div), 1234);
      chk("R2 rf_ref_div", int'(rf_ref_div), 555);
      chk("R6 ref_common", int'(ref_common), 1);
      chk("R6 if_pd_pol", int'(if_pd_pol), 1);
      chk("R5 rf_pd_pol", int'(rf_pd_pol), 1);

      // R3: shifting without a strobe changes nothing
      shift_word(mk_ifref(1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 15'd77));
      ticks(8);
      chk("R3 if_ref_div", int'(if_ref_div), 1234);
      chk("R3 rf_ref_div", int'(rf_ref_div), 555);

      // R8: static levels, output 1 high, output 0 low
      load_word(mk_iffb(3'b000, 4'b0010, 12'd100, 3'd1));
      chk("R8 gp_out", int'(gp_out), 2);
      chk("R8 gp_oe", int'(gp_oe), 3);

      // R9: fast-lock with RF 8x set and IF x8 clear
      load_word(mk_rfref(4'd8, 1'b0, 15'd10));
      load_word(mk_ifref(1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 15'd10));
      load_word(mk_iffb(3'b000, 4'b1011, 12'd100, 3'd1));
      chk("R9 gp_oe rf8 only", int'(gp_oe), 1);
      chk("R9 gp_out", int'(gp_out), 0);
      load_word(mk_ifref(1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 15'd10));
      chk("R9 gp_oe both", int'(gp_oe), 3);
      load_word(mk_rfref(4'd7, 1'b0, 15'd10));
      chk("R9 gp_oe if only", int'(gp_oe), 2);

      // R10: power bits and enable pins
      load_word(mk_iffb(3'b101, 4'b0000, 12'd100, 3'd1));
      load_word(mk_rffb(3'b001, 10'd40, 5'd3, 4'd1));
      chk("R10 if_powered", int'(if_powered), 1);
      chk("R10 rf_powered", int'(rf_powered), 1);
      chk("R10 if_cnt_rst", int'(if_cnt_rst), 1);
      chk("R10 if_pd_mode", int'(if_pd_mode), 1);
      chk("R10 rf_presc_hi", int'(rf_presc_hi), 1);
      if_en = 1'b0;
      ticks(2);
      chk("R10 if pin low", int'(if_powered), 0);
      load_word(mk_rffb(3'b010, 10'd40, 5'd3, 4'd1));
      chk("R10 rf pwdn bit", int'(rf_powered), 0);

      // R12: latching with both enables low
      rf_en = 1'b0;
      load_word(mk_rfref(4'd1, 1'b0, 15'd777));
      chk("R12 rf_ref_div", int'(rf_ref_div), 777);
      chk("R12 rf_cp_current", int'(rf_cp_current), 200);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule